// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block gathers the interrupt sources of a buffered serial port into one level interrupt. It watches the occupancy counts of the receive and transmit FIFOs and compares them against two programmable trigger levels. From these it forms a live status word that is recomputed every cycle. Each true live condition is latched into a sticky status register on the next clock edge. Single-cycle event pulses from the serial datapath also set sticky bits. These events are receive overrun, receive timeout, framing error, parity error, modem-line change and transmit overflow.

Software enables sources through a mask. The mask has no direct write. Bits are added through a set port and removed through a clear port. The interrupt line is high while any enabled sticky bit is set. Software acknowledges an interrupt by writing ones to the sticky register. A small synchronous register port with one address bus is provided. Writes act on the clock edge. Reads are combinational from the addressed register.

Top module: `uart_irq_aggregator`

## Requirements
- R1: The live status word (read at address 6, also on port `liveStatus`) holds the following bits, and every other bit reads 0:
  - bit0: receive count >= receive trigger.
  - bit1: receive count == 0.
  - bit2: receive count == FIFO depth.
  - bit3: transmit count == 0.
  - bit4: transmit count == FIFO depth.
  - bit13: transmit count >= transmit trigger.
- R2: On each clock edge, every live bit 0..4 that is true sets the same sticky bit. A true transmit-trigger condition sets sticky bit 10.
- R3: A one-cycle event pulse sets its sticky bit on the next edge, as follows:
  - receive overrun: bit5
  - framing error: bit6
  - parity error: bit7
  - receive timeout: bit8
  - modem change: bit9
  - transmit overflow: bit12
- R4: Writing the sticky register (address 3) clears each bit written as 1. Bits written as 0 keep their value.
- R5: When a clear write and a set condition hit the same sticky bit in one cycle, the bit ends up set.
- R6: A write to address 0 ORs the data into the 16-bit enable mask. The mask reads back at address 2.
- R7: A write to address 1 clears the mask bits written as 1. A write to address 2 leaves the mask unchanged.
- R8: `irqOut` is high exactly when some bit is set in both the mask and the sticky register.
- R9: While reset is held, the mask and the sticky register read 0, both trigger levels read 32, and `irqOut` is low.
- R10: The receive and transmit trigger levels are written and read at addresses 4 and 5. Addresses 0, 1 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxCount | input | CntW | Receive FIFO occupancy |
| txCount | input | CntW | Transmit FIFO occupancy |
| evRxOverrun | input | 1 | Receive overrun pulse |
| evRxTimeout | input | 1 | Receive timeout pulse |
| evFrame | input | 1 | Framing error pulse |
| evParity | input | 1 | Parity error pulse |
| evModem | input | 1 | Modem line change pulse |
| evTxOverflow | input | 1 | Transmit overflow pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the addressed register |
| liveStatus | output | 16 | Live status word |
| irqOut | output | 1 | Level interrupt |

## Verification
The live status word is tried with a table of count and trigger combinations. The table includes empty, full, one below and exactly at each trigger, and triggers of 0 and of the full depth. These separate a `>=` compare from a `>` compare. They also separate the empty and full flags from the trigger flags, and the transmit-trigger bit position from its sticky position. Directed sequences then cover the following:
- Events pulsed one at a time and together, which tells apart each sticky bit position.
- A partial write-one-to-clear, which shows that zeros in the data preserve bits.
- A clear coinciding with an event, which shows which side wins.
- Mask set, clear and ignored direct writes, paired with masked and unmasked events, which shows that the interrupt follows only enabled bits.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int DataW = 16;
  localparam int AddrW = 3;

  // register addresses
  localparam logic [AddrW-1:0] AddrEnSet  = 3'd0;
  localparam logic [AddrW-1:0] AddrEnClr  = 3'd1;
  localparam logic [AddrW-1:0] AddrMask   = 3'd2;
  localparam logic [AddrW-1:0] AddrSticky = 3'd3;
  localparam logic [AddrW-1:0] AddrRxTrig = 3'd4;
  localparam logic [AddrW-1:0] AddrTxTrig = 3'd5;
  localparam logic [AddrW-1:0] AddrLive   = 3'd6;

  // live status bit positions
  localparam int LvRxTrig  = 0;
  localparam int LvRxEmpty = 1;
  localparam int LvRxFull  = 2;
  localparam int LvTxEmpty = 3;
  localparam int LvTxFull  = 4;
  localparam int LvTxTrig  = 13;
  localparam int LvFifoBits = 5;

  // sticky-only bit positions
  localparam int StOverrun  = 5;
  localparam int StFrame    = 6;
  localparam int StParity   = 7;
  localparam int StTimeout  = 8;
  localparam int StModem    = 9;
  localparam int StTxTrig   = 10;
  localparam int StTxOvf    = 12;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic stickyClr;
    logic rxTrigWr;
    logic txTrigWr;
  } uirq_strb_t;

  typedef struct packed {
    logic overrun;
    logic timeout;
    logic frame;
    logic parity;
    logic modem;
    logic txOverflow;
  } uirq_evt_t;

endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic             regWrEn,
  input  logic [AddrW-1:0] regAddr,
  output uirq_strb_t       strb
);

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr)
        AddrEnSet:  strb.enSet     = 1'b1;
        AddrEnClr:  strb.enClr     = 1'b1;
        AddrSticky: strb.stickyClr = 1'b1;
        AddrRxTrig: strb.rxTrigWr  = 1'b1;
        AddrTxTrig: strb.txTrigWr  = 1'b1;
        default:    strb = '0;
      endcase
    end
  end

  always_comb begin
    assert ($onehot0(strb)) else $error("p_one_strobe_r7: several strobes at once");
  end

endmodule

// File: rtl/uirq_live.sv
module uirq_live
  import uirq_pkg::*;
#(
  parameter int FifoDepth = 64,
  parameter int CntW      = $clog2(FifoDepth + 1)
) (
  input  logic [CntW-1:0]  rxCount,
  input  logic [CntW-1:0]  txCount,
  input  logic [CntW-1:0]  rxTrig,
  input  logic [CntW-1:0]  txTrig,
  output logic [DataW-1:0] live
);

  localparam logic [CntW-1:0] Full = CntW'(FifoDepth);

  always_comb begin
    live = '0;
    live[LvRxTrig]  = (rxCount >= rxTrig);
    live[LvRxEmpty] = (rxCount == '0);
    live[LvRxFull]  = (rxCount == Full);
    live[LvTxEmpty] = (txCount == '0);
    live[LvTxFull]  = (txCount == Full);
    live[LvTxTrig]  = (txCount >= txTrig);
  end

  always_comb begin
    assert (!(live[LvRxFull] && live[LvRxEmpty]))
      else $error("p_rx_full_empty_r1: both flags high");
    assert (!(live[LvTxFull] && live[LvTxEmpty]))
      else $error("p_tx_full_empty_r1: both flags high");
  end

endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int FifoDepth = 64,
  parameter int CntW      = $clog2(FifoDepth + 1),
  parameter int TrigReset = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  uirq_strb_t       strb,
  input  logic [DataW-1:0] wrData,
  input  logic [AddrW-1:0] rdAddr,
  input  logic [DataW-1:0] live,
  input  uirq_evt_t        evt,
  output logic [CntW-1:0]  rxTrig,
  output logic [CntW-1:0]  txTrig,
  output logic [DataW-1:0] rdData,
  output logic             irqOut
);

  localparam logic [CntW-1:0] TrigInit = CntW'(TrigReset);

  logic [DataW-1:0] maskQ, maskD;
  logic [DataW-1:0] stickyQ, stickyD;
  logic [DataW-1:0] setVec, clrVec, setMaskVec, clrMaskVec;
  logic [CntW-1:0]  rxTrigQ, txTrigQ;

  // set sources: fifo conditions, relocated tx trigger, datapath events
  always_comb begin
    setVec = '0;
    setVec[LvFifoBits-1:0] = live[LvFifoBits-1:0];
    setVec[StTxTrig] = live[LvTxTrig];
    setVec[StOverrun] = evt.overrun;
    setVec[StFrame]   = evt.frame;
    setVec[StParity]  = evt.parity;
    setVec[StTimeout] = evt.timeout;
    setVec[StModem]   = evt.modem;
    setVec[StTxOvf]   = evt.txOverflow;
  end

  assign clrVec     = strb.stickyClr ? wrData : '0;
  assign setMaskVec = strb.enSet ? wrData : '0;
  assign clrMaskVec = strb.enClr ? wrData : '0;

  // set has priority over clear
  assign stickyD = (stickyQ & ~clrVec) | setVec;
  assign maskD   = (maskQ | setMaskVec) & ~clrMaskVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      stickyQ <= '0;
      rxTrigQ <= TrigInit;
      txTrigQ <= TrigInit;
    end else begin
      maskQ   <= maskD;
      stickyQ <= stickyD;
      if (strb.rxTrigWr) rxTrigQ <= wrData[CntW-1:0];
      if (strb.txTrigWr) txTrigQ <= wrData[CntW-1:0];
    end
  end

  assign rxTrig = rxTrigQ;
  assign txTrig = txTrigQ;
  assign irqOut = |(maskQ & stickyQ);

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      AddrMask:   rdData = maskQ;
      AddrSticky: rdData = stickyQ;
      AddrRxTrig: rdData = DataW'(rxTrigQ);
      AddrTxTrig: rdData = DataW'(txTrigQ);
      AddrLive:   rdData = live;
      default:    rdData = '0;
    endcase
  end

  // assertions
  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
    evt.overrun |=> stickyQ[StOverrun]);

  p_txtrig_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    live[LvTxTrig] |=> stickyQ[StTxTrig]);

  p_sticky_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(stickyQ) & ~$past(clrVec) & ~stickyQ) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stickyClr && wrData[StParity] && evt.parity) |=> stickyQ[StParity]);

  p_mask_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enSet && !strb.enClr) |=> $stable(maskQ));

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ != '0 && stickyQ != '0));

endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator
  import uirq_pkg::*;
#(
  parameter int FifoDepth = 64,
  parameter int TrigReset = 32,
  localparam int CntW     = $clog2(FifoDepth + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CntW-1:0]  rxCount,
  input  logic [CntW-1:0]  txCount,
  input  logic             evRxOverrun,
  input  logic             evRxTimeout,
  input  logic             evFrame,
  input  logic             evParity,
  input  logic             evModem,
  input  logic             evTxOverflow,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [15:0]      regWrData,
  output logic [15:0]      regRdData,
  output logic [15:0]      liveStatus,
  output logic             irqOut
);

  uirq_strb_t      strb;
  uirq_evt_t       evt;
  logic [CntW-1:0] rxTrig, txTrig;

  assign evt = '{overrun: evRxOverrun, timeout: evRxTimeout, frame: evFrame,
                 parity: evParity, modem: evModem, txOverflow: evTxOverflow};

  uirq_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  uirq_live #(.FifoDepth(FifoDepth), .CntW(CntW)) uLive (
    .rxCount (rxCount),
    .txCount (txCount),
    .rxTrig  (rxTrig),
    .txTrig  (txTrig),
    .live    (liveStatus)
  );

  uirq_regs #(.FifoDepth(FifoDepth), .CntW(CntW), .TrigReset(TrigReset)) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (regWrData),
    .rdAddr (regAddr),
    .live   (liveStatus),
    .evt    (evt),
    .rxTrig (rxTrig),
    .txTrig (txTrig),
    .rdData (regRdData),
    .irqOut (irqOut)
  );

endmodule

// File: tb/tb_uart_irq_aggregator.sv
module tb_uart_irq_aggregator;

  localparam int CntW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CntW-1:0] rxCount = '0, txCount = '0;
  logic evRxOverrun = 0, evRxTimeout = 0, evFrame = 0, evParity = 0, evModem = 0, evTxOverflow = 0;
  logic regWrEn = 0;
  logic [2:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData, liveStatus;
  logic irqOut;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_aggregator dut (.*);

  // {rxCount, txCount, rxTrig, txTrig, expected live word}
  localparam logic [43:0] Vecs [0:7] = '{
    {7'd0,  7'd0,  7'd32, 7'd32, 16'h000A},
    {7'd64, 7'd64, 7'd32, 7'd32, 16'h2015},
    {7'd31, 7'd32, 7'd32, 7'd32, 16'h2000},
    {7'd32, 7'd31, 7'd32, 7'd32, 16'h0001},
    {7'd5,  7'd0,  7'd0,  7'd1,  16'h0009},
    {7'd0,  7'd63, 7'd0,  7'd64, 16'h0003},
    {7'd64, 7'd1,  7'd64, 7'd1,  16'h2005},
    {7'd10, 7'd10, 7'd11, 7'd9,  16'h2000}
  };

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 0;
  endtask

  task automatic rdChk(string tag, logic [2:0] a, logic [15:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    // R9: reset state
    rdChk("R9 mask", 3'd2, 16'h0000);
    rdChk("R9 sticky", 3'd3, 16'h0000);
    rdChk("R9 rx trig", 3'd4, 16'd32);
    rdChk("R9 tx trig", 3'd5, 16'd32);
    chk("R9 irq", {15'd0, irqOut}, 16'd0);
    rstN = 1;
    tick();
    // R2: empty flags latched one edge after reset
    rdChk("R2 empty flags sticky", 3'd3, 16'h000A);
    // R10 write-only addresses read zero
    rdChk("R10 addr0", 3'd0, 16'h0000);
    rdChk("R10 addr1", 3'd1, 16'h0000);
    rdChk("R10 addr7", 3'd7, 16'h0000);

    // R1 table walk
    for (int i = 0; i < 8; i++) begin
      wr(3'd4, {9'd0, Vecs[i][29:23]});
      wr(3'd5, {9'd0, Vecs[i][22:16]});
      rxCount = Vecs[i][43:37];
      txCount = Vecs[i][36:30];
      #1;
      chk($sformatf("R1 vec%0d port", i), liveStatus, Vecs[i][15:0]);
      rdChk($sformatf("R1 vec%0d read", i), 3'd6, Vecs[i][15:0]);
    end
    rdChk("R10 rx trig readback", 3'd4, 16'd11);
    rdChk("R10 tx trig readback", 3'd5, 16'd9);

    // neutral counts, clear everything
    rxCount = 7'd5; txCount = 7'd5;
    wr(3'd4, 16'd32);
    wr(3'd5, 16'd32);
    tick();
    wr(3'd3, 16'hFFFF);
    rdChk("R4 clear all", 3'd3, 16'h0000);

    // R3 events
    evFrame = 1; tick(); evFrame = 0;
    rdChk("R3 frame bit6", 3'd3, 16'h0040);
    evRxOverrun = 1; evParity = 1; evRxTimeout = 1; evModem = 1; evTxOverflow = 1;
    tick();
    evRxOverrun = 0; evParity = 0; evRxTimeout = 0; evModem = 0; evTxOverflow = 0;
    rdChk("R3 all events", 3'd3, 16'h13E0);

    // R4 partial clear
    wr(3'd3, 16'h0060);
    rdChk("R4 partial clear", 3'd3, 16'h1380);

    // R2 tx trigger relocates to bit10
    txCount = 7'd40;
    tick();
    chk("R1 tx trig live bit13", liveStatus, 16'h2000);
    txCount = 7'd5;
    rdChk("R2 tx trig sticky bit10", 3'd3, 16'h1780);

    // R5 set wins
    regWrEn = 1; regAddr = 3'd3; regWrData = 16'h0020; evRxOverrun = 1;
    tick();
    regWrEn = 0; evRxOverrun = 0;
    rdChk("R5 set wins", 3'd3, 16'h17A0);
    wr(3'd3, 16'hFFFF);
    rdChk("R4 clear again", 3'd3, 16'h0000);

    // R6 / R7 mask
    wr(3'd0, 16'h0041);
    rdChk("R6 set mask", 3'd2, 16'h0041);
    wr(3'd0, 16'h0100);
    rdChk("R6 or mask", 3'd2, 16'h0141);
    wr(3'd1, 16'h0001);
    rdChk("R7 clear mask", 3'd2, 16'h0140);
    wr(3'd2, 16'hFFFF);
    rdChk("R7 direct write ignored", 3'd2, 16'h0140);

    // R8 interrupt
    chk("R8 idle irq", {15'd0, irqOut}, 16'd0);
    evParity = 1; tick(); evParity = 0;
    chk("R8 masked event no irq", {15'd0, irqOut}, 16'd0);
    evRxTimeout = 1; tick(); evRxTimeout = 0;
    chk("R8 enabled event irq", {15'd0, irqOut}, 16'd1);
    wr(3'd3, 16'h0100);
    chk("R8 irq after ack", {15'd0, irqOut}, 16'd0);
    rdChk("R4 parity kept", 3'd3, 16'h0080);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule